// File: doc/BRIEF.md
# Programmable NAND Bus Timing Sequencer

This block turns single host accesses into strobe waveforms on an asynchronous NAND flash bus. The host selects the cycle type by the port it touches: a write to the command port produces a command-latch cycle, a write to the address port produces one address-latch cycle (a multi-byte address is sent as a run of such single-byte accesses), and a write or read on the data port produces a data cycle. Two configuration words, a control word and a timing word, set the bus width, the enables and the cycle counts.

Every access runs through a fixed order of phases: a pre phase (one cycle, stretched by a read turnaround delay and by a busy device), a setup phase with the chip enabled and the strobe still high, a strobe phase with the write or read strobe low, a hold phase with the strobe high again, and a high-impedance phase in which the bus is released before the next access may begin. A read that directly follows a command or an address cycle gets its own programmable extra delay, so the device has time to switch to output mode.

Top module: `nand_seq_top`

## Requirements
- R1: Host address map: 0 control word, 1 timing word, 2 command port, 3 address port, 4 data port (reads only on 4). Control word: bit 0 soft reset, bit 1 wait-on-ready, bit 2 enable, bit 4 16-bit width, bits 12:9 command-to-read delay, bits 16:13 address-to-read delay. Timing word: setup 7:0, strobe 15:8, hold 23:16, high-impedance 31:24.
- R2: After reset the sequencer is idle: chip enable, write and read strobes high, command and address latches low, bus not driven, busy low, read-valid low.
- R3: An accepted access lasts one pre cycle, then max(setup,1) setup cycles, max(strobe,1)+1 cycles with the strobe low, max(hold,1) hold cycles and exactly high-impedance-count cycles of release, then returns to idle.
- R4: Chip enable is low during setup, strobe and hold; the command latch is high in those phases only for command-port accesses, the address latch only for address-port accesses.
- R5: For writes (command, address, data) the bus is driven during setup, strobe and hold and released (value 0, enable low) in every other phase; the write strobe is the active strobe.
- R6: For data-port reads the read strobe is low in the strobe phase, the bus is never driven, and read-valid pulses for one cycle in the first hold cycle carrying the bus value sampled at the end of the strobe phase.
- R7: Command and address cycles carry only bits 7:0 with upper bits 0; data cycles carry bits 15:0 when 16-bit width is set, otherwise bits 7:0 with the upper byte 0, and read data is masked the same way.
- R8: A read that directly follows a command access has its pre phase lengthened by the command-to-read delay; one following an address access by the address-to-read delay; other accesses get no extra delay.
- R9: With wait-on-ready set, the sequencer stays in the pre phase while the ready input is low; with it clear, the ready input has no effect.
- R10: Busy is high for the whole access; port accesses presented while busy are ignored.
- R11: Writes to the control or timing word while busy are ignored.
- R12: Port accesses are ignored while enable is clear or soft reset is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe (data port) |
| hostAddr | input | 3 | Host register/port select |
| hostWrData | input | 32 | Host write data |
| rdData | output | 16 | Data returned by a read access |
| rdValid | output | 1 | One-cycle pulse marking rdData valid |
| busy | output | 1 | Access in progress |
| nandRdy | input | 1 | Device ready (low = busy) |
| nandDqIn | input | 16 | Bus value from the device |
| nandDqOut | output | 16 | Bus value towards the device |
| nandDqOe | output | 1 | Bus drive enable |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |

## Verification
The assertions watch, cycle by cycle, that the command and address latches never overlap, that a strobe only falls inside an enabled chip and lasts at least two cycles, that the bus is never driven while the read strobe is low, that the pre phase holds on a busy device and that the configuration does not move during an access. The exact phase lengths for each timing value, the turnaround delays chosen by the previous access, the byte masking and the ignored accesses are only visible from the bench, which sweeps every combination of small setup, strobe, hold and release counts and compares every pin in every cycle against a trace computed from the counts.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int ADDR_W = 3;
  localparam int CNT_W  = 8;
  localparam int DLY_W  = 4;

  localparam logic [ADDR_W-1:0] SEL_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_TIME = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_CMD  = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_ADR  = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_DATA = 3'd4;

  // control word bit positions
  localparam int B_SOFTRST = 0;
  localparam int B_WAITON  = 1;
  localparam int B_ENABLE  = 2;
  localparam int B_WIDE    = 4;
  localparam int B_CLEDLY  = 9;
  localparam int B_ALEDLY  = 13;

  typedef enum logic [1:0] {
    KIND_CMD, KIND_ADR, KIND_WRITE, KIND_READ
  } accKind_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_SETUP, PH_STROBE, PH_HOLD, PH_HIZ
  } phase_t;

  typedef struct packed {
    logic             softRst;
    logic             waitOn;
    logic             enable;
    logic [DLY_W-1:0] cleDelay;
    logic [DLY_W-1:0] aleDelay;
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] hold;
    logic [CNT_W-1:0] hiz;
  } seqTiming_t;

  // control -> datapath strobes
  typedef struct packed {
    logic idle;
    logic accept;
    logic capture;
    logic driveBus;
  } seqStrobes_t;

  // control -> pins
  typedef struct packed {
    logic busActive;
    logic cle;
    logic ale;
    logic weLow;
    logic reLow;
  } pinCtl_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqTiming_t        tim,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              nandRdy,
  output seqStrobes_t       stb,
  output pinCtl_t           pins,
  output logic              busy
);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  accKind_t         kindQ;
  accKind_t         lastKind;

  logic             reqWr;
  logic             reqRd;
  accKind_t         reqKind;
  logic             accept;
  logic             stall;
  logic [CNT_W-1:0] preDelay;
  logic [CNT_W-1:0] effSetup;
  logic [CNT_W-1:0] effStrobe;
  logic [CNT_W-1:0] effHold;

  always_comb begin
    reqWr = hostWrEn &&
            (hostAddr == SEL_CMD || hostAddr == SEL_ADR || hostAddr == SEL_DATA);
    reqRd = !reqWr && hostRdEn && (hostAddr == SEL_DATA);
    if (hostAddr == SEL_CMD)      reqKind = KIND_CMD;
    else if (hostAddr == SEL_ADR) reqKind = KIND_ADR;
    else if (reqRd)               reqKind = KIND_READ;
    else                          reqKind = KIND_WRITE;
    accept = (phase == PH_IDLE) && (reqWr || reqRd) && tim.enable && !tim.softRst;
  end

  always_comb begin
    preDelay = '0;
    if (reqKind == KIND_READ) begin
      if (lastKind == KIND_CMD)      preDelay = CNT_W'(tim.cleDelay);
      else if (lastKind == KIND_ADR) preDelay = CNT_W'(tim.aleDelay);
    end
    effSetup  = (tim.setup  == '0) ? CNT_W'(1) : tim.setup;
    effStrobe = (tim.strobe == '0) ? CNT_W'(1) : tim.strobe;
    effHold   = (tim.hold   == '0) ? CNT_W'(1) : tim.hold;
    stall     = tim.waitOn && !nandRdy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      kindQ    <= KIND_WRITE;
      lastKind <= KIND_WRITE;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase    <= PH_PRE;
            cnt      <= preDelay;
            kindQ    <= reqKind;
            lastKind <= reqKind;
          end
        end
        PH_PRE: begin
          if (!stall) begin
            if (cnt == '0) begin
              phase <= PH_SETUP;
              cnt   <= effSetup - CNT_W'(1);
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_STROBE;
            cnt   <= effStrobe;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            phase <= PH_HOLD;
            cnt   <= effHold - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            if (tim.hiz == '0) begin
              phase <= PH_IDLE;
            end else begin
              phase <= PH_HIZ;
              cnt   <= tim.hiz - CNT_W'(1);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_HIZ: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - CNT_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  logic active;
  logic isRead;

  always_comb begin
    active         = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    isRead         = (kindQ == KIND_READ);
    stb.idle       = (phase == PH_IDLE);
    stb.accept     = accept;
    stb.capture    = (phase == PH_STROBE) && (cnt == '0) && isRead;
    stb.driveBus   = active && !isRead;
    pins.busActive = active;
    pins.cle       = active && (kindQ == KIND_CMD);
    pins.ale       = active && (kindQ == KIND_ADR);
    pins.weLow     = (phase == PH_STROBE) && !isRead;
    pins.reLow     = (phase == PH_STROBE) && isRead;
    busy           = (phase != PH_IDLE);
  end

  // R4: the two latch enables never overlap
  a_r4_latch_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pins.cle && pins.ale));

  // R3: a strobe, once low, stays low for at least one more cycle
  a_r3_strobe_two_cycles: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pins.weLow || pins.reLow) |=> (pins.weLow || pins.reLow));

  // R3: the strobe rises into the hold phase
  a_r3_hold_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pins.weLow || pins.reLow) |-> (phase == PH_HOLD));

  // R9: a busy device keeps the sequencer in its pre phase
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PRE && tim.waitOn && !nandRdy) |=> (phase == PH_PRE));

  // R10: an accepted access always enters the pre phase
  a_r10_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (phase == PH_PRE && busy));

endmodule

// File: rtl/nand_seq_datapath.sv
module nand_seq_datapath
  import nand_seq_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [HOST_W-1:0] hostWrData,
  input  seqStrobes_t       stb,
  input  logic [BUS_W-1:0]  nandDqIn,
  output seqTiming_t        tim,
  output logic [BUS_W-1:0]  nandDqOut,
  output logic              nandDqOe,
  output logic [BUS_W-1:0]  rdData,
  output logic              rdValid
);

  localparam int HALF = BUS_W / 2;

  logic             wide;
  logic [BUS_W-1:0] outLatch;
  logic [BUS_W-1:0] nextOut;
  logic [BUS_W-1:0] sampled;
  logic             cfgWrite;

  assign cfgWrite = hostWrEn && stb.idle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tim  <= '0;
      wide <= 1'b0;
    end else if (cfgWrite && hostAddr == SEL_CTRL) begin
      tim.softRst  <= hostWrData[B_SOFTRST];
      tim.waitOn   <= hostWrData[B_WAITON];
      tim.enable   <= hostWrData[B_ENABLE];
      wide         <= hostWrData[B_WIDE];
      tim.cleDelay <= hostWrData[B_CLEDLY +: DLY_W];
      tim.aleDelay <= hostWrData[B_ALEDLY +: DLY_W];
    end else if (cfgWrite && hostAddr == SEL_TIME) begin
      tim.setup  <= hostWrData[0*CNT_W +: CNT_W];
      tim.strobe <= hostWrData[1*CNT_W +: CNT_W];
      tim.hold   <= hostWrData[2*CNT_W +: CNT_W];
      tim.hiz    <= hostWrData[3*CNT_W +: CNT_W];
    end
  end

  always_comb begin
    if (hostAddr == SEL_DATA && wide) nextOut = hostWrData[BUS_W-1:0];
    else                              nextOut = BUS_W'(hostWrData[HALF-1:0]);
    sampled = wide ? nandDqIn : BUS_W'(nandDqIn[HALF-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (stb.accept) outLatch <= nextOut;
      rdValid <= stb.capture;
      if (stb.capture) rdData <= sampled;
    end
  end

  assign nandDqOe  = stb.driveBus;
  assign nandDqOut = stb.driveBus ? outLatch : '0;

  // R11: configuration holds still across a running access
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.idle && $past(!stb.idle)) |-> ($stable(tim) && $stable(wide)));

  // R6: read-valid is a single-cycle pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R7: in 8-bit mode a returned word never carries an upper byte
  a_r7_narrow_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !wide && $stable(wide)) |-> (rdData[BUS_W-1:HALF] == '0));

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [HOST_W-1:0] hostWrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              rdValid,
  output logic              busy,
  input  logic              nandRdy,
  input  logic [BUS_W-1:0]  nandDqIn,
  output logic [BUS_W-1:0]  nandDqOut,
  output logic              nandDqOe,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN
);

  seqTiming_t  tim;
  seqStrobes_t stb;
  pinCtl_t     pins;

  nand_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tim      (tim),
    .hostWrEn (hostWrEn),
    .hostRdEn (hostRdEn),
    .hostAddr (hostAddr),
    .nandRdy  (nandRdy),
    .stb      (stb),
    .pins     (pins),
    .busy     (busy)
  );

  nand_seq_datapath #(.BUS_W(BUS_W), .HOST_W(HOST_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .stb        (stb),
    .nandDqIn   (nandDqIn),
    .tim        (tim),
    .nandDqOut  (nandDqOut),
    .nandDqOe   (nandDqOe),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );

  assign nandCeN = !pins.busActive;
  assign nandCle = pins.cle;
  assign nandAle = pins.ale;
  assign nandWeN = !pins.weLow;
  assign nandReN = !pins.reLow;

  // R5: never drive the bus while the device may be driving it
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDqOe);

  // R4: strobes only inside an enabled chip
  a_r4_strobe_in_ce: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !nandCeN);

  // R10: busy covers every bus activity
  a_r10_busy_covers: assert property (@(posedge clk) disable iff (!rstN)
    (!nandCeN || nandDqOe) |-> busy);

endmodule

// File: tb/nand_seq_top_tb.sv
`timescale 1ns/1ps
module nand_seq_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [15:0] rdData;
  logic        rdValid;
  logic        busy;
  logic        nandRdy = 1'b1;
  logic [15:0] nandDqIn = '0;
  logic [15:0] nandDqOut;
  logic        nandDqOe;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN;

  always #5 clk = ~clk;

  nand_seq_top u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .rdData(rdData),
    .rdValid(rdValid), .busy(busy), .nandRdy(nandRdy), .nandDqIn(nandDqIn),
    .nandDqOut(nandDqOut), .nandDqOe(nandDqOe), .nandCeN(nandCeN),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // configuration model
  int cSet = 1, cStr = 1, cHold = 1, cHiz = 0, cCle = 0, cAle = 0;
  bit cWide = 1, cWait = 0, cEn = 1, cRst = 0;
  int lastKind = 2; // 0 cmd, 1 addr, 2 write, 3 read

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic applyCfg();
    logic [31:0] c, t;
    c = 32'(cRst) | (32'(cWait) << 1) | (32'(cEn) << 2) | (32'(cWide) << 4)
        | (32'(cCle) << 9) | (32'(cAle) << 13);
    t = 32'(cSet) | (32'(cStr) << 8) | (32'(cHold) << 16) | (32'(cHiz) << 24);
    hostWrite(3'd0, c);
    hostWrite(3'd1, t);
  endtask

  // kind: 0 cmd, 1 addr, 2 data write, 3 data read
  // inject: 0 none, 1 port write during busy, 2 timing write during busy
  task automatic doAccess(input int kind, input logic [15:0] data, input int stall,
                          input int inject, input bit ignored, input string tag);
    int d, s, w, h, z, p, total, bad, ph;
    logic [7:0]  gotV, expV;
    logic [15:0] expDq, expRd;
    bit act, expValid;
    string msg;
    d = 0;
    if (kind == 3 && lastKind == 0) d = cCle;
    if (kind == 3 && lastKind == 1) d = cAle;
    s = (cSet == 0) ? 1 : cSet;
    w = ((cStr == 0) ? 1 : cStr) + 1;
    h = (cHold == 0) ? 1 : cHold;
    z = cHiz;
    p = (cWait ? stall : 0) + d + 1;
    total = p + s + w + h + z;
    bad = 0;
    msg = "";
    nandDqIn = data ^ 16'h5AC3;
    expRd = cWide ? nandDqIn : {8'h00, nandDqIn[7:0]};
    if (stall > 0) nandRdy = 1'b0;
    @(negedge clk);
    hostAddr = (kind == 0) ? 3'd2 : (kind == 1) ? 3'd3 : 3'd4;
    hostWrEn = (kind != 3);
    hostRdEn = (kind == 3);
    hostWrData = {16'hBEEF, data};
    for (int i = 0; i < (ignored ? 6 : total + 3); i++) begin
      @(negedge clk);
      if (i == 0) begin hostWrEn = 1'b0; hostRdEn = 1'b0; end
      if (i == 1 && inject == 1) begin
        hostAddr = 3'd2; hostWrData = 32'h0000_0077; hostWrEn = 1'b1;
      end
      if (i == 1 && inject == 2) begin
        hostAddr = 3'd1; hostWrData = 32'hFFFF_FFFF; hostWrEn = 1'b1;
      end
      if (i == 2) hostWrEn = 1'b0;
      if (ignored)            ph = 0;
      else if (i < p)         ph = 1;
      else if (i < p + s)     ph = 2;
      else if (i < p + s + w) ph = 3;
      else if (i < p + s + w + h) ph = 4;
      else if (i < total)     ph = 5;
      else                    ph = 0;
      act = (ph >= 2 && ph <= 4);
      expValid = !ignored && kind == 3 && i == p + s + w;
      if (act && kind != 3)
        expDq = (kind == 2 && cWide) ? data : {8'h00, data[7:0]};
      else
        expDq = 16'h0000;
      expV = {ph != 0, !act, act && kind == 0, act && kind == 1,
              !(ph == 3 && kind != 3), !(ph == 3 && kind == 3),
              act && kind != 3, expValid};
      gotV = {busy, nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDqOe, rdValid};
      if (gotV !== expV || nandDqOut !== expDq || (expValid && rdData !== expRd)) begin
        if (bad == 0)
          msg = $sformatf("kind=%0d cycle=%0d pins got=%b exp=%b dq got=%h exp=%h rd got=%h exp=%h",
                          kind, i, gotV, expV, nandDqOut, expDq, rdData, expRd);
        bad++;
      end
      if (i >= stall) nandRdy = 1'b1;
    end
    nandRdy = 1'b1;
    check(bad == 0, tag, msg);
    if (!ignored) lastKind = kind;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2: reset state
    check({busy, nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDqOe, rdValid} === 8'b01001100
          && nandDqOut === 16'h0, "R2",
          $sformatf("reset pins got=%b exp=01001100", {busy, nandCeN, nandCle, nandAle,
                    nandWeN, nandReN, nandDqOe, rdValid}));

    // R12: reset leaves enable clear, accesses dropped
    doAccess(0, 16'h0011, 0, 0, 1, "R12 disabled after reset");

    // R1 R3: distinct per-field counts
    cEn = 1; cWide = 1; cSet = 5; cStr = 2; cHold = 7; cHiz = 4;
    applyCfg();
    doAccess(2, 16'h1234, 0, 0, 0, "R1 field positions");
    // R3: zero counts clamp to one
    cSet = 0; cStr = 0; cHold = 0; cHiz = 0;
    applyCfg();
    doAccess(2, 16'h4321, 0, 0, 0, "R3 zero clamp");

    // sweep of timing counts with each access type
    cCle = 2; cAle = 3;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        for (int h = 0; h < 4; h++)
          for (int z = 0; z < 4; z++) begin
            cSet = s; cStr = w; cHold = h; cHiz = z;
            applyCfg();
            doAccess(0, 16'(s * 64 + w * 16 + h * 4 + z), 0, 0, 0, "R4 command cycle");
            doAccess(1, 16'(8'hA0 + z), 0, 0, 0, "R4 address cycle");
            doAccess(2, 16'hC3A5 ^ 16'(s * 4096 + z), 0, 0, 0, "R5 data write");
            doAccess(3, 16'h0F0F ^ 16'(w * 256 + h), 0, 0, 0, "R6 data read");
          end

    // R8: turnaround delays, every delay value
    cSet = 1; cStr = 1; cHold = 1; cHiz = 1;
    for (int dl = 0; dl < 16; dl++) begin
      cCle = dl; cAle = 15 - dl;
      applyCfg();
      doAccess(0, 16'h0030, 0, 0, 0, "R8 command");
      doAccess(3, 16'h1111, 0, 0, 0, "R8 read after command");
      doAccess(1, 16'h0005, 0, 0, 0, "R8 address");
      doAccess(3, 16'h2222, 0, 0, 0, "R8 read after address");
      doAccess(3, 16'h3333, 0, 0, 0, "R8 read after read");
    end

    // R7: 8-bit width
    cWide = 0; applyCfg();
    doAccess(2, 16'hA5C3, 0, 0, 0, "R7 narrow write");
    doAccess(3, 16'h9966, 0, 0, 0, "R7 narrow read");
    doAccess(0, 16'hFF90, 0, 0, 0, "R7 narrow command");
    cWide = 1; applyCfg();
    doAccess(1, 16'hEE12, 0, 0, 0, "R7 wide address stays byte");

    // R9: ready gating
    cWait = 1; applyCfg();
    doAccess(0, 16'h0070, 4, 0, 0, "R9 stall on busy device");
    doAccess(2, 16'h5555, 1, 0, 0, "R9 single stall");
    cWait = 0; applyCfg();
    doAccess(0, 16'h0071, 4, 0, 0, "R9 ready ignored");

    // R10, R11: activity while busy
    cSet = 2; cStr = 3; cHold = 2; cHiz = 2; applyCfg();
    doAccess(2, 16'h7E7E, 0, 1, 0, "R10 port access during busy");
    doAccess(3, 16'h1357, 0, 2, 0, "R11 timing write during busy");
    doAccess(2, 16'h2468, 0, 0, 0, "R11 timing unchanged afterwards");

    // R12: soft reset and enable
    cRst = 1; applyCfg();
    doAccess(2, 16'h0BAD, 0, 0, 1, "R12 soft reset");
    cRst = 0; cEn = 0; applyCfg();
    doAccess(3, 16'h0BAD, 0, 0, 1, "R12 enable clear");
    cEn = 1; applyCfg();
    doAccess(2, 16'h600D, 0, 0, 0, "R12 re-enabled");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule